// File: doc/BRIEF.md
# Reloadable DMA Transfer Counter

This block keeps the byte count of a DMA transfer for a storage-bus controller. Software programs a 24-bit start count through three byte-wide register writes. Reads of the same three registers return the live current count. When a command arrives with its DMA flag set, the live count is reloaded from the start count. A start count of zero is taken to mean 65536 bytes.

Data reaches the counter through a pseudo-DMA port. This is a valid/ready stream of either one byte or one 16-bit word. Each byte is passed on to a byte-wide output stream, and each byte passed on lowers the count by one. A byte that arrives while the count is already zero is still accepted, but it is dropped and the count stays where it is. The block gives a one-cycle pulse when the count reaches zero, keeps a terminal-count status flag, and reacts to an external DMA-done event.

Until software first writes the high count byte, reads of that byte return a fixed chip-identification constant instead of the count.

Back-pressure rules:
- A word on the input is taken when `pd_valid_i` and `pd_ready_o` are both high at a clock edge.
- `pd_ready_o` may depend on `byte_ready_i` in the same cycle.
- `pd_ready_o` stays low while the low half of an accepted 16-bit word is still waiting to go out.
- `byte_valid_o` is high only while a byte is waiting and the count is not zero. Its data holds steady until `byte_ready_i` is seen high.

Top module: `dma_xfer_counter`

## Requirements
- R1: Count reads are combinational and little-endian. Read select 0 returns count bits 7:0, select 1 returns bits 15:8, select 2 returns bits 23:16, and select 3 returns 0.
- R2: A register write to select 0, 1 or 2 changes only the matching byte of the start count. The current count is not changed by it.
- R3: A register write to select 0, 1 or 2 clears the terminal-count flag in the next cycle, unless a DMA-done event occurs in the same cycle.
- R4: A command write whose bit 7 is 1 loads the current count from the start count as it stood before that edge. A command with bit 7 at 0 leaves the count unchanged.
- R5: If the start count is zero when a command with bit 7 set is written, the current count becomes 0x010000.
- R6: Each byte taken on the output stream lowers the count by one at that clock edge. A same-cycle DMA-done event or reload takes priority over this decrement.
- R7: A byte offered while the count is zero is consumed without being forwarded. In that case `byte_valid_o` stays low and the count is unchanged.
- R8: A 16-bit input word (`pd_wide_i`=1) leaves the block as two bytes, bits 15:8 first and then bits 7:0. A narrow word forwards bits 7:0.
- R9: Read select 2 returns the parameter `CHIP_ID` until select 2 has been written once since the last hard or soft reset. After that it returns the count's high byte.
- R10: A DMA-done event forces the count to zero and sets the terminal-count flag at the next edge. It also gives a one-cycle `dma_done_o` pulse in the cycle after the event; this pulse tells the neighbouring logic to set the bus-service interrupt and clear the sequence step and FIFO flags.
- R11: A soft reset clears the start count, the current count, the flag, the held byte and the written-once mark at the next edge.
- R12: `cnt_zero_o` pulses for one cycle, starting in the first cycle after the decrement that takes the count from 1 to 0.
- R13: While the count is not zero and `byte_ready_i` is low, `pd_ready_o` is low and nothing is consumed.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous hard reset, active low |
| soft_rst_i | input | 1 | Synchronous soft reset |
| reg_wr_i | input | 1 | Count register write strobe |
| reg_wsel_i | input | 2 | Write select: 0 low, 1 middle, 2 high |
| reg_wdata_i | input | 8 | Write data |
| reg_rsel_i | input | 2 | Read select |
| reg_rdata_o | output | 8 | Read data (combinational) |
| cmd_wr_i | input | 1 | Command write strobe |
| cmd_i | input | 8 | Command byte; bit 7 is the DMA flag |
| pd_valid_i | input | 1 | Pseudo-DMA word valid |
| pd_ready_o | output | 1 | Pseudo-DMA word ready |
| pd_wide_i | input | 1 | 1: 16-bit word, 0: single byte |
| pd_data_i | input | 16 | Pseudo-DMA data |
| byte_valid_o | output | 1 | Forwarded byte valid |
| byte_ready_i | input | 1 | Forwarded byte ready |
| byte_data_o | output | 8 | Forwarded byte |
| dma_done_i | input | 1 | DMA-done event |
| tc_flag_o | output | 1 | Terminal-count status flag |
| cnt_zero_o | output | 1 | Count-reached-zero pulse |
| dma_done_o | output | 1 | Registered DMA-done pulse for neighbouring logic |

## Verification
Some results are combinational and appear in the same cycle as their inputs. These are the read data and the stream signals (`byte_valid_o`, `byte_data_o`, `pd_ready_o`). Every register-held result appears one edge after its stimulus. These are the count, the start count, the flag, the chip-ID mark and the two pulses, so a count changed at an edge is visible on the very next read. The bench drives inputs just after a falling edge and updates its behavioural model at the rising edge from those same inputs. It compares the outputs with the model at the following falling edge, which is half a cycle after the edge that caused them and before any input moves.

// File: rtl/dmacnt_pkg.sv
package dmacnt_pkg;
  localparam int BYTE_W = 8;
  localparam int SEL_W  = 2;
  localparam int DMA_FLAG_BIT = 7;

  typedef enum logic [SEL_W-1:0] {
    SEL_LO   = 2'd0,
    SEL_MID  = 2'd1,
    SEL_HI   = 2'd2,
    SEL_NONE = 2'd3
  } cnt_sel_e;
endpackage

// File: rtl/dmacnt_split.sv
// Splits an accepted 16-bit word into two bytes, high byte first.
module dmacnt_split
  import dmacnt_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              soft_rst_i,
  input  logic              in_valid_i,
  input  logic              in_wide_i,
  input  logic [15:0]       in_data_i,
  input  logic              take_i,      // current byte consumed this cycle
  output logic              cur_valid_o,
  output logic [BYTE_W-1:0] cur_byte_o,
  output logic              busy_o       // low half still held
);
  logic              pend_q;
  logic [BYTE_W-1:0] pend_byte_q;

  always_comb begin
    if (pend_q) begin
      cur_valid_o = 1'b1;
      cur_byte_o  = pend_byte_q;
    end else begin
      cur_valid_o = in_valid_i;
      cur_byte_o  = in_wide_i ? in_data_i[15:8] : in_data_i[7:0];
    end
  end

  assign busy_o = pend_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pend_q      <= 1'b0;
      pend_byte_q <= '0;
    end else if (soft_rst_i) begin
      pend_q      <= 1'b0;
      pend_byte_q <= '0;
    end else if (pend_q) begin
      if (take_i) pend_q <= 1'b0;
    end else if (take_i && in_wide_i) begin
      pend_q      <= 1'b1;
      pend_byte_q <= in_data_i[7:0];
    end
  end

  AST_WIDE_HOLDS_LOW: assert property (@(posedge clk) disable iff (!rst_n)
    (!pend_q && take_i && in_valid_i && in_wide_i && !soft_rst_i)
      |=> (pend_q && pend_byte_q == $past(in_data_i[7:0]))) else $error("split"); // R8

  AST_HELD_BYTE_STABLE: assert property (@(posedge clk) disable iff (!rst_n)
    (pend_q && !take_i && !soft_rst_i) |=> (pend_q && $stable(pend_byte_q))) else $error("hold"); // R13
endmodule

// File: rtl/dmacnt_core.sv
// Start count, current count, terminal-count flag and written-once mark.
module dmacnt_core
  import dmacnt_pkg::*;
#(
  parameter int CNT_W = 24,
  parameter logic [CNT_W-1:0] ZERO_RELOAD = CNT_W'(32'h0001_0000)
)(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              soft_rst_i,
  input  logic              wr_en_i,
  input  logic [SEL_W-1:0]  wr_sel_i,
  input  logic [BYTE_W-1:0] wr_data_i,
  input  logic              load_i,
  input  logic              dec_i,
  input  logic              done_i,
  output logic [CNT_W-1:0]  cnt_o,
  output logic              tc_flag_o,
  output logic              zero_pulse_o,
  output logic              done_pulse_o,
  output logic              hi_written_o
);
  localparam int NB = CNT_W / BYTE_W;

  logic [NB-1:0][BYTE_W-1:0] start_q;
  logic [CNT_W-1:0]          start_flat;
  logic [CNT_W-1:0]          cnt_q;
  logic                      tc_flag_q, zero_q, done_q, hi_wr_q;
  logic                      cnt_wr;

  assign start_flat = start_q;
  assign cnt_wr     = wr_en_i && (wr_sel_i < SEL_W'(NB));

  for (genvar g = 0; g < NB; g++) begin : g_lane
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                                    start_q[g] <= '0;
      else if (soft_rst_i)                           start_q[g] <= '0;
      else if (wr_en_i && wr_sel_i == SEL_W'(g))     start_q[g] <= wr_data_i;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q     <= '0;
      tc_flag_q <= 1'b0;
      zero_q    <= 1'b0;
      done_q    <= 1'b0;
      hi_wr_q   <= 1'b0;
    end else if (soft_rst_i) begin
      cnt_q     <= '0;
      tc_flag_q <= 1'b0;
      zero_q    <= 1'b0;
      done_q    <= 1'b0;
      hi_wr_q   <= 1'b0;
    end else begin
      if (done_i)                         cnt_q <= '0;
      else if (load_i)                    cnt_q <= (start_flat == '0) ? ZERO_RELOAD : start_flat;
      else if (dec_i && cnt_q != '0)      cnt_q <= cnt_q - CNT_W'(1);

      if (done_i)                         tc_flag_q <= 1'b1;
      else if (cnt_wr)                    tc_flag_q <= 1'b0;

      zero_q  <= dec_i && !done_i && !load_i && (cnt_q == CNT_W'(1));
      done_q  <= done_i;
      if (wr_en_i && wr_sel_i == SEL_W'(NB-1)) hi_wr_q <= 1'b1;
    end
  end

  assign cnt_o        = cnt_q;
  assign tc_flag_o    = tc_flag_q;
  assign zero_pulse_o = zero_q;
  assign done_pulse_o = done_q;
  assign hi_written_o = hi_wr_q;

  AST_IDLE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (!dec_i && !load_i && !done_i && !soft_rst_i) |=> $stable(cnt_q)) else $error("idle"); // R2

  AST_FLAG_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
    (cnt_wr && !done_i && !soft_rst_i) |=> !tc_flag_q) else $error("flag"); // R3

  AST_RELOAD: assert property (@(posedge clk) disable iff (!rst_n)
    (load_i && !done_i && !soft_rst_i && start_flat != '0) |=> cnt_q == $past(start_flat)) else $error("reload"); // R4

  AST_RELOAD_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    (load_i && !done_i && !soft_rst_i && start_flat == '0) |=> cnt_q == ZERO_RELOAD) else $error("reload0"); // R5

  AST_DEC_ONE: assert property (@(posedge clk) disable iff (!rst_n)
    (dec_i && !load_i && !done_i && !soft_rst_i && cnt_q != '0)
      |=> cnt_q == $past(cnt_q) - CNT_W'(1)) else $error("dec"); // R6

  AST_DONE: assert property (@(posedge clk) disable iff (!rst_n)
    (done_i && !soft_rst_i) |=> (cnt_q == '0 && tc_flag_q && done_q)) else $error("done"); // R10

  AST_ZERO_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    zero_q |-> (cnt_q == '0 && $past(cnt_q) == CNT_W'(1))) else $error("zero"); // R12
endmodule

// File: rtl/dma_xfer_counter.sv
module dma_xfer_counter
  import dmacnt_pkg::*;
#(
  parameter int CNT_W = 24,
  parameter logic [BYTE_W-1:0] CHIP_ID = 8'h5C,
  parameter logic [CNT_W-1:0]  ZERO_RELOAD = CNT_W'(32'h0001_0000)
)(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              soft_rst_i,
  input  logic              reg_wr_i,
  input  logic [SEL_W-1:0]  reg_wsel_i,
  input  logic [BYTE_W-1:0] reg_wdata_i,
  input  logic [SEL_W-1:0]  reg_rsel_i,
  output logic [BYTE_W-1:0] reg_rdata_o,
  input  logic              cmd_wr_i,
  input  logic [7:0]        cmd_i,
  input  logic              pd_valid_i,
  output logic              pd_ready_o,
  input  logic              pd_wide_i,
  input  logic [15:0]       pd_data_i,
  output logic              byte_valid_o,
  input  logic              byte_ready_i,
  output logic [BYTE_W-1:0] byte_data_o,
  input  logic              dma_done_i,
  output logic              tc_flag_o,
  output logic              cnt_zero_o,
  output logic              dma_done_o
);
  localparam int NB = CNT_W / BYTE_W;

  logic [CNT_W-1:0]  cnt;
  logic              hi_written, cnt_is_zero;
  logic              cur_valid, busy, take, fwd, load;
  logic [BYTE_W-1:0] cur_byte;

  assign cnt_is_zero = (cnt == '0);
  assign take        = cur_valid && (cnt_is_zero || byte_ready_i);
  assign fwd         = cur_valid && !cnt_is_zero && byte_ready_i;
  assign load        = cmd_wr_i && cmd_i[DMA_FLAG_BIT];

  assign pd_ready_o   = !busy && (cnt_is_zero || byte_ready_i);
  assign byte_valid_o = cur_valid && !cnt_is_zero;
  assign byte_data_o  = cur_byte;

  dmacnt_split u_split (
    .clk         (clk),
    .rst_n       (rst_n),
    .soft_rst_i  (soft_rst_i),
    .in_valid_i  (pd_valid_i),
    .in_wide_i   (pd_wide_i),
    .in_data_i   (pd_data_i),
    .take_i      (take),
    .cur_valid_o (cur_valid),
    .cur_byte_o  (cur_byte),
    .busy_o      (busy)
  );

  dmacnt_core #(.CNT_W(CNT_W), .ZERO_RELOAD(ZERO_RELOAD)) u_core (
    .clk          (clk),
    .rst_n        (rst_n),
    .soft_rst_i   (soft_rst_i),
    .wr_en_i      (reg_wr_i),
    .wr_sel_i     (reg_wsel_i),
    .wr_data_i    (reg_wdata_i),
    .load_i       (load),
    .dec_i        (fwd),
    .done_i       (dma_done_i),
    .cnt_o        (cnt),
    .tc_flag_o    (tc_flag_o),
    .zero_pulse_o (cnt_zero_o),
    .done_pulse_o (dma_done_o),
    .hi_written_o (hi_written)
  );

  always_comb begin
    reg_rdata_o = '0;
    for (int i = 0; i < NB; i++)
      if (reg_rsel_i == SEL_W'(i)) reg_rdata_o = cnt[i*BYTE_W +: BYTE_W];
    if (reg_rsel_i == SEL_W'(NB-1) && !hi_written) reg_rdata_o = CHIP_ID;
  end

  AST_NO_TAKE_STALLED: assert property (@(posedge clk) disable iff (!rst_n)
    (!cnt_is_zero && !byte_ready_i && !soft_rst_i && !load && !dma_done_i) |=> $stable(cnt)) else $error("stall"); // R13

  AST_SOFT_RESET: assert property (@(posedge clk) disable iff (!rst_n)
    soft_rst_i |=> (cnt == '0 && !tc_flag_o && !hi_written && !busy)) else $error("soft"); // R11
endmodule

// File: tb/dma_xfer_counter_tb.sv
module dma_xfer_counter_tb;
  localparam logic [7:0] CHIP = 8'h5C;

  logic clk = 0, rst_n = 0, soft_rst = 0;
  logic reg_wr = 0; logic [1:0] wsel = 0; logic [7:0] wdata = 0;
  logic [1:0] rsel = 0; logic [7:0] rdata;
  logic cmd_wr = 0; logic [7:0] cmd = 0;
  logic pd_valid = 0, pd_ready, pd_wide = 0; logic [15:0] pd_data = 0;
  logic bvalid, bready = 1; logic [7:0] bdata;
  logic done_in = 0, tc_flag, zero_o, done_o;

  always #4 clk = ~clk; // 125 MHz

  dma_xfer_counter #(.CHIP_ID(CHIP)) u_dut (
    .clk(clk), .rst_n(rst_n), .soft_rst_i(soft_rst),
    .reg_wr_i(reg_wr), .reg_wsel_i(wsel), .reg_wdata_i(wdata),
    .reg_rsel_i(rsel), .reg_rdata_o(rdata),
    .cmd_wr_i(cmd_wr), .cmd_i(cmd),
    .pd_valid_i(pd_valid), .pd_ready_o(pd_ready), .pd_wide_i(pd_wide), .pd_data_i(pd_data),
    .byte_valid_o(bvalid), .byte_ready_i(bready), .byte_data_o(bdata),
    .dma_done_i(done_in), .tc_flag_o(tc_flag), .cnt_zero_o(zero_o), .dma_done_o(done_o));

  int checks = 0, fails = 0;
  bit lfsr_on = 0;
  logic [7:0] lfsr = 8'h1;

  // behavioural model state
  int m_stc [3];
  int m_tc = 0;
  bit m_flag = 0, m_hiwr = 0, m_pend = 0, m_zero = 0, m_done = 0;
  int m_pbyte = 0;

  task automatic chk(string what, int act, int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h at %0t", what, act, exp, $time);
    end
  endtask

  function automatic int cur_byte();
    if (m_pend) return m_pbyte;
    return pd_wide ? int'(pd_data[15:8]) : int'(pd_data[7:0]);
  endfunction

  function automatic bit cur_valid();
    return m_pend || pd_valid;
  endfunction

  // model update at the rising edge, from the inputs held across it
  always @(posedge clk) begin
    if (!rst_n || soft_rst) begin
      foreach (m_stc[i]) m_stc[i] = 0;
      m_tc = 0; m_flag = 0; m_hiwr = 0; m_pend = 0; m_zero = 0; m_done = 0; m_pbyte = 0;
    end else begin
      bit take, fwd, load;
      int stc_val;
      take = cur_valid() && (m_tc == 0 || bready);
      fwd  = cur_valid() && m_tc != 0 && bready;
      load = cmd_wr && cmd[7];
      stc_val = m_stc[0] + (m_stc[1] << 8) + (m_stc[2] << 16);
      if (m_pend) begin
        if (take) m_pend = 0;
      end else if (take && pd_wide) begin
        m_pend = 1; m_pbyte = pd_data[7:0];
      end
      m_zero = fwd && !done_in && !load && m_tc == 1;
      m_done = done_in;
      if (done_in) m_tc = 0;
      else if (load) m_tc = (stc_val == 0) ? 32'h10000 : stc_val;
      else if (fwd) m_tc = m_tc - 1;
      if (done_in) m_flag = 1;
      else if (reg_wr && wsel != 2'd3) m_flag = 0;
      if (reg_wr && wsel != 2'd3) m_stc[wsel] = wdata;
      if (reg_wr && wsel == 2'd2) m_hiwr = 1;
    end
    if (lfsr_on) lfsr <= {lfsr[6:0], lfsr[7] ^ lfsr[5] ^ lfsr[4] ^ lfsr[3]};
  end

  always @(posedge clk) if (lfsr_on) #1 bready = lfsr[0] | lfsr[2];

  // compare every cycle, half a cycle after the edge
  always @(negedge clk) if (rst_n) begin
    int exp_rd;
    case (rsel)
      2'd0: exp_rd = m_tc & 8'hFF;
      2'd1: exp_rd = (m_tc >> 8) & 8'hFF;
      2'd2: exp_rd = m_hiwr ? ((m_tc >> 16) & 8'hFF) : int'(CHIP);
      default: exp_rd = 0;
    endcase
    chk("R1 R9 reg_rdata", rdata, exp_rd);
    chk("R3 tc_flag", tc_flag, m_flag);
    chk("R7 byte_valid", bvalid, cur_valid() && m_tc != 0);
    if (bvalid) chk("R8 byte_data", bdata, cur_byte());
    chk("R13 pd_ready", pd_ready, !m_pend && (m_tc == 0 || bready));
    chk("R12 cnt_zero", zero_o, m_zero);
    chk("R10 dma_done", done_o, m_done);
  end

  task automatic step(); @(negedge clk); #1; endtask

  task automatic wr_reg(int sel, int d);
    reg_wr = 1; wsel = 2'(sel); wdata = 8'(d); step(); reg_wr = 0;
  endtask

  task automatic wr_cmd(int c);
    cmd_wr = 1; cmd = 8'(c); step(); cmd_wr = 0;
  endtask

  task automatic push(bit wide, int d);
    pd_valid = 1; pd_wide = wide; pd_data = 16'(d);
    do @(negedge clk); while (!pd_ready);
    @(posedge clk); #1; pd_valid = 0;
  endtask

  // directed read: sample a register at the next falling edge
  task automatic rd_expect(int sel, int exp, string req);
    rsel = 2'(sel); @(negedge clk); chk(req, rdata, exp); #1;
  endtask

  initial begin
    int cyc = 0;
    forever begin
      @(posedge clk); cyc++;
      if (cyc > 20000) begin
        fails++; checks++;
        $display("FAIL watchdog expired");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
        $finish;
      end
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    #1 rst_n = 1; step();
    // reset state and chip ID (R9, R1)
    rd_expect(2, CHIP, "R9 chip id after reset");
    rd_expect(0, 0, "R1 low byte after reset");
    chk("R3 flag after reset", tc_flag, 0);
    // start count writes do not touch current count (R2)
    wr_reg(0, 8'h05); wr_reg(1, 8'h00);
    rd_expect(0, 0, "R2 current count unchanged by start write");
    rd_expect(2, CHIP, "R9 chip id before high write");
    wr_reg(2, 8'h00);
    rd_expect(2, 0, "R9 high byte after write");
    // command without DMA bit (R4), then with
    wr_cmd(8'h10);
    rd_expect(0, 0, "R4 no reload without DMA bit");
    wr_cmd(8'h90);
    rd_expect(0, 5, "R4 reload from start count");
    // narrow and wide bytes (R6, R8, R12)
    push(0, 16'h00A1);
    push(1, 16'hB2C3);
    rd_expect(0, 2, "R6 count after three bytes");
    push(1, 16'hD4E5);
    rd_expect(0, 0, "R12 count reached zero");
    // bytes at zero count are discarded (R7)
    push(0, 16'h0077); push(1, 16'h1234);
    step(); step();
    rd_expect(0, 0, "R7 count unchanged after discard");
    // done and flag clear (R10, R3)
    done_in = 1; step(); done_in = 0;
    chk("R10 flag set by done", tc_flag, 1);
    wr_reg(1, 8'h00);
    chk("R3 flag cleared by count write", tc_flag, 0);
    // zero start count reloads 0x10000 (R5)
    wr_reg(0, 0);
    wr_cmd(8'h80);
    rd_expect(0, 0, "R5 low byte of 0x10000");
    rd_expect(1, 0, "R5 mid byte of 0x10000");
    rd_expect(2, 1, "R5 high byte of 0x10000");
    // back-pressure with varying ready (R13)
    wr_reg(0, 8'h09); wr_reg(1, 8'h01); wr_cmd(8'h81);
    lfsr_on = 1;
    for (int i = 0; i < 40; i++) push(i[0], 16'h1000 + i * 16'h0111);
    lfsr_on = 0; step(); bready = 1;
    // done during stream and reload colliding with a byte (R6, R10)
    pd_valid = 1; pd_wide = 1; pd_data = 16'hCAFE; cmd_wr = 1; cmd = 8'h80;
    step(); cmd_wr = 0; done_in = 1; step(); done_in = 0; pd_valid = 0;
    step(); step();
    // soft reset clears everything (R11)
    wr_reg(2, 8'h03); wr_cmd(8'h80);
    soft_rst = 1; step(); soft_rst = 0;
    rd_expect(2, CHIP, "R11 chip id after soft reset");
    rd_expect(0, 0, "R11 count cleared");
    chk("R11 flag cleared", tc_flag, 0);
    repeat (4) step();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end
endmodule